// File: doc/BRIEF.md
# Shared Tagged Receive Buffer

This block gathers characters arriving on several serial lines into one shared queue that a host drains one word at a time. Each line presents a finished character, together with its framing and parity error flags, by raising a one-cycle strobe. The block turns every accepted character into a 16-bit word. The word carries the character, the number of the line it came from, its error flags, an overrun marker and a data-valid flag. Because every word is tagged with its line, characters from all lines can share one queue. The host reads the head word and, in the same cycle, pops it. It keeps polling until the valid flag comes back clear.

A per-line parameter write sets the character size, stop bits, parity mode, baud code and receiver enable for one line. These settings are driven out to the deserialisers. Only the receiver enable acts inside this block. A receive-done output is high while the queue holds data. The receive interrupt is that condition gated by a host-supplied enable. A break needs no marker of its own. It arrives as a zero character with the framing flag set, and it is stored like any other character.

When the queue is full, any character that arrives is dropped. A two-state overrun tracker then marks the next stored word. Its state `OVR_CLEAN` means no character has been lost since the last stored word. Its state `OVR_LOST` means a loss is still unreported. The tracker moves from `OVR_CLEAN` to `OVR_LOST` on any drop. It moves from `OVR_LOST` to `OVR_CLEAN` when a word is stored in a cycle with no drop. It stays in `OVR_LOST` when a drop and a store happen together.

Top module: `tagged_rx_buffer`

## Requirements
- R1: A stored word is laid out as follows: bits [7:0] hold the character, [9:8] the line number, [11:10] read as zero, [12] the parity error, [13] the framing error, [14] the overrun marker and [15] the valid flag.
- R2: Words leave in arrival order; asserting `rd_en` while data is present pops the word shown on `rd_data` at the next rising edge.
- R3: While the queue is non-empty, `rx_done` is high and `rd_data[15]` is set.
- R4: When the queue is empty, `rd_data` reads 16'h0000, so bit 15 is clear, and `rx_done` is low.
- R5: A zero character delivered with its framing flag set is stored as character 8'h00 with bit 13 set and nothing else added.
- R6: `rx_irq` is high exactly when `rx_done` and `rie` are both high.
- R7: A parameter write uses this layout: `lp_data[2:0]` selects the line, [4:3] the character size, [5] the stop bits, [6] the parity enable, [7] odd parity, [11:8] the baud code and [12] the receiver enable. The fields appear on that line's outputs after the next edge. A select of 4 or more changes nothing.
- R8: A strobe on a line whose receiver enable is clear stores nothing.
- R9: The queue holds 16 words. A character that arrives while the queue is full is dropped. The next word stored after such a drop has bit 14 set, and later words have it clear.
- R10: Characters from several lines in one cycle are stored in ascending line order.
- R11: After reset the queue is empty, every receiver enable is clear, the character size fields are 2'b11, and the stop, parity and baud fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ln_stb | input | 4 | Per-line character strobe |
| ln_char | input | 32 | Per-line character, line i in bits [8i+7:8i] |
| ln_ferr | input | 4 | Per-line framing error flag |
| ln_perr | input | 4 | Per-line parity error flag |
| lp_wr | input | 1 | Line parameter write strobe |
| lp_data | input | 13 | Line parameter write data |
| rd_en | input | 1 | Host read; pops the head word |
| rie | input | 1 | Receive interrupt enable |
| rd_data | output | 16 | Head word, or zero when empty |
| rx_done | output | 1 | Queue holds data |
| rx_irq | output | 1 | Receive interrupt |
| line_size | output | 8 | Character size code, 2 bits per line |
| line_stop | output | 4 | Stop bit selection per line |
| line_par_en | output | 4 | Parity enable per line |
| line_par_odd | output | 4 | Odd parity per line |
| line_baud | output | 16 | Baud code, 4 bits per line |
| line_rxen | output | 4 | Receiver enable per line |

## Verification
The assertions check on every cycle that an empty queue reads as zero, that a non-empty one shows the valid flag and zeros in the spare field, and that the fill level never passes the depth. They also check that a parameter write lands in the addressed receiver enable, and that strobes on disabled lines leave an empty queue empty. Only the bench scenarios can show the content and order of the words. That covers the ascending store of same-cycle arrivals, the break encoding, and the loss of exactly the newest character when the queue is full. It also covers the single overrun marker on the next word that is stored.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int WORD_W    = 16;
    localparam int CHAR_W    = 8;
    localparam int LID_W     = 2;                 // line tag width in a word
    localparam int ENT_W     = WORD_W - 1;        // valid bit is not stored
    localparam int LP_W      = 13;
    localparam int LSEL_W    = 3;                 // line select in a parameter write
    // parameter write field positions
    localparam int LP_SIZE_LSB = 3;
    localparam int LP_STOP_BIT = 5;
    localparam int LP_PEN_BIT  = 6;
    localparam int LP_ODD_BIT  = 7;
    localparam int LP_BAUD_LSB = 8;
    localparam int LP_RXEN_BIT = 12;

    typedef enum logic [0:0] {
        OVR_CLEAN = 1'b0,
        OVR_LOST  = 1'b1
    } ovr_state_e;
endpackage

// File: rtl/srb_line_cfg.sv
module srb_line_cfg
    import srb_pkg::*;
#(
    parameter int N_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lp_wr,
    input  logic [LP_W-1:0]      lp_data,
    output logic [2*N_LINES-1:0] cfg_size,
    output logic [N_LINES-1:0]   cfg_stop,
    output logic [N_LINES-1:0]   cfg_pen,
    output logic [N_LINES-1:0]   cfg_odd,
    output logic [4*N_LINES-1:0] cfg_baud,
    output logic [N_LINES-1:0]   cfg_rxen
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic hit;
        assign hit = lp_wr && (lp_data[LSEL_W-1:0] == LSEL_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_size[2*i +: 2] <= 2'b11;
                cfg_stop[i]        <= 1'b0;
                cfg_pen[i]         <= 1'b0;
                cfg_odd[i]         <= 1'b0;
                cfg_baud[4*i +: 4] <= 4'h0;
                cfg_rxen[i]        <= 1'b0;
            end else if (hit) begin
                cfg_size[2*i +: 2] <= lp_data[LP_SIZE_LSB +: 2];
                cfg_stop[i]        <= lp_data[LP_STOP_BIT];
                cfg_pen[i]         <= lp_data[LP_PEN_BIT];
                cfg_odd[i]         <= lp_data[LP_ODD_BIT];
                cfg_baud[4*i +: 4] <= lp_data[LP_BAUD_LSB +: 4];
                cfg_rxen[i]        <= lp_data[LP_RXEN_BIT];
            end
        end
    end
endmodule

// File: rtl/srb_arbiter.sv
module srb_arbiter #(
    parameter int N_LINES = 4,
    parameter int CNT_W   = 5
) (
    input  logic [N_LINES-1:0]       want,
    input  logic [CNT_W-1:0]         space,
    output logic [N_LINES-1:0]       acc,
    output logic [N_LINES-1:0]       first,
    output logic [N_LINES*CNT_W-1:0] off_flat,
    output logic [CNT_W-1:0]         n_acc,
    output logic                     drop_any
);
    always_comb begin
        logic [CNT_W-1:0] run;
        logic             seen;
        run      = '0;
        seen     = 1'b0;
        acc      = '0;
        first    = '0;
        off_flat = '0;
        n_acc    = '0;
        for (int i = 0; i < N_LINES; i++) begin
            off_flat[i*CNT_W +: CNT_W] = run;
            if (want[i]) begin
                if (run < space) begin
                    acc[i] = 1'b1;
                    n_acc  = n_acc + 1'b1;
                    if (!seen) first[i] = 1'b1;
                    seen = 1'b1;
                end
                run = run + 1'b1;
            end
        end
        drop_any = |(want & ~acc);
    end
endmodule

// File: rtl/srb_fifo.sv
module srb_fifo #(
    parameter int DEPTH   = 16,
    parameter int N_LINES = 4,
    parameter int ENT_W   = 15,
    parameter int CNT_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINES-1:0]       push,
    input  logic [N_LINES*CNT_W-1:0] off_flat,
    input  logic [N_LINES*ENT_W-1:0] ent_flat,
    input  logic [CNT_W-1:0]         n_push,
    input  logic                     pop,
    output logic [ENT_W-1:0]         head,
    output logic [CNT_W-1:0]         level
);
    localparam int AW = $clog2(DEPTH);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_idx [N_LINES];
    logic             pop_ok;

    assign pop_ok = pop && (level != '0);
    assign head   = mem[rd_ptr];

    always_comb begin
        for (int i = 0; i < N_LINES; i++)
            wr_idx[i] = wr_ptr + off_flat[i*CNT_W +: AW];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_LINES; i++)
            if (push[i]) mem[wr_idx[i]] <= ent_flat[i*ENT_W +: ENT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + n_push[AW-1:0];
            rd_ptr <= rd_ptr + AW'(pop_ok);
            level  <= level + n_push - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/tagged_rx_buffer.sv
module tagged_rx_buffer
    import srb_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int DEPTH   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_LINES-1:0]          ln_stb,
    input  logic [N_LINES*CHAR_W-1:0]   ln_char,
    input  logic [N_LINES-1:0]          ln_ferr,
    input  logic [N_LINES-1:0]          ln_perr,
    input  logic                        lp_wr,
    input  logic [LP_W-1:0]             lp_data,
    input  logic                        rd_en,
    input  logic                        rie,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        rx_done,
    output logic                        rx_irq,
    output logic [2*N_LINES-1:0]        line_size,
    output logic [N_LINES-1:0]          line_stop,
    output logic [N_LINES-1:0]          line_par_en,
    output logic [N_LINES-1:0]          line_par_odd,
    output logic [4*N_LINES-1:0]        line_baud,
    output logic [N_LINES-1:0]          line_rxen
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [N_LINES-1:0]       want, acc, first;
    logic [N_LINES*CNT_W-1:0] off_flat;
    logic [N_LINES*ENT_W-1:0] ent_flat;
    logic [CNT_W-1:0]         n_acc, fill_lvl, space;
    logic [ENT_W-1:0]         head;
    logic                     drop_any;
    logic                     mark_en;
    ovr_state_e               ovr_q, ovr_d;

    srb_line_cfg #(.N_LINES(N_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .lp_wr(lp_wr), .lp_data(lp_data),
        .cfg_size(line_size), .cfg_stop(line_stop), .cfg_pen(line_par_en),
        .cfg_odd(line_par_odd), .cfg_baud(line_baud), .cfg_rxen(line_rxen)
    );

    assign want  = ln_stb & line_rxen;
    assign space = CNT_W'(DEPTH) - fill_lvl;

    srb_arbiter #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_arb (
        .want(want), .space(space), .acc(acc), .first(first),
        .off_flat(off_flat), .n_acc(n_acc), .drop_any(drop_any)
    );

    // overrun tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= OVR_CLEAN;
        else        ovr_q <= ovr_d;
    end

    // overrun tracker: transitions and marking output
    always_comb begin
        ovr_d   = ovr_q;
        mark_en = 1'b0;
        unique case (ovr_q)
            OVR_CLEAN: begin
                if (drop_any) ovr_d = OVR_LOST;
            end
            OVR_LOST: begin
                mark_en = 1'b1;
                if (drop_any)      ovr_d = OVR_LOST;
                else if (|acc)     ovr_d = OVR_CLEAN;
            end
            default: ovr_d = OVR_CLEAN;
        endcase
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_ent
        assign ent_flat[i*ENT_W +: ENT_W] = {
            mark_en & first[i], ln_ferr[i], ln_perr[i], 2'b00,
            LID_W'(i), ln_char[i*CHAR_W +: CHAR_W]
        };
    end

    srb_fifo #(.DEPTH(DEPTH), .N_LINES(N_LINES), .ENT_W(ENT_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(acc), .off_flat(off_flat),
        .ent_flat(ent_flat), .n_push(n_acc), .pop(rd_en),
        .head(head), .level(fill_lvl)
    );

    assign rx_done = (fill_lvl != '0);
    assign rd_data = rx_done ? {1'b1, head} : '0;
    assign rx_irq  = rx_done & rie;
endmodule

// File: rtl/srb_chk.sv
module srb_chk #(
    parameter int N_LINES = 4,
    parameter int DEPTH   = 16,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic               rx_done,
    input logic [15:0]        rd_data,
    input logic               lp_wr,
    input logic [2:0]         lp_sel,
    input logic               lp_rxen,
    input logic [N_LINES-1:0] ln_stb,
    input logic [N_LINES-1:0] line_rxen,
    input logic [CNT_W-1:0]   fill_lvl
);
    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> rd_data == 16'h0000);

    // R3
    valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> rd_data[15]);

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[11:10] == 2'b00);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= CNT_W'(DEPTH));

    // R7
    rxen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_wr && !lp_sel[2]) |=> line_rxen[$past(lp_sel[1:0])] == $past(lp_rxen));

    // R8
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_done && ((ln_stb & line_rxen) == '0)) |=> !rx_done);
endmodule

bind tagged_rx_buffer srb_chk #(.N_LINES(N_LINES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rx_done(rx_done), .rd_data(rd_data),
    .lp_wr(lp_wr), .lp_sel(lp_data[2:0]), .lp_rxen(lp_data[12]), .ln_stb(ln_stb),
    .line_rxen(line_rxen), .fill_lvl(fill_lvl)
);

// File: tb/tb_tagged_rx_buffer.sv
module tb_tagged_rx_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {line, char, ferr, perr, expected word}
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 8'h41, 1'b0, 1'b0, 16'h8041},
        {2'd1, 8'h5A, 1'b0, 1'b0, 16'h815A},
        {2'd2, 8'hFF, 1'b0, 1'b1, 16'h92FF},
        {2'd3, 8'h00, 1'b1, 1'b0, 16'hA300},
        {2'd1, 8'h7E, 1'b1, 1'b1, 16'hB17E},
        {2'd2, 8'h00, 1'b0, 1'b0, 16'h8200},
        {2'd3, 8'hC3, 1'b0, 1'b1, 16'h93C3},
        {2'd0, 8'h00, 1'b1, 1'b0, 16'hA000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ln_stb = '0;
    logic [31:0] ln_char = '0;
    logic [3:0]  ln_ferr = '0;
    logic [3:0]  ln_perr = '0;
    logic        lp_wr = 1'b0;
    logic [12:0] lp_data = '0;
    logic        rd_en = 1'b0;
    logic        rie = 1'b0;
    logic [15:0] rd_data;
    logic        rx_done, rx_irq;
    logic [7:0]  line_size;
    logic [3:0]  line_stop, line_par_en, line_par_odd, line_rxen;
    logic [15:0] line_baud;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_rx_buffer dut (
        .clk(clk), .rst_n(rst_n), .ln_stb(ln_stb), .ln_char(ln_char),
        .ln_ferr(ln_ferr), .ln_perr(ln_perr), .lp_wr(lp_wr), .lp_data(lp_data),
        .rd_en(rd_en), .rie(rie), .rd_data(rd_data), .rx_done(rx_done),
        .rx_irq(rx_irq), .line_size(line_size), .line_stop(line_stop),
        .line_par_en(line_par_en), .line_par_odd(line_par_odd),
        .line_baud(line_baud), .line_rxen(line_rxen)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input int line, input logic [7:0] ch,
                                         input bit ovr, input bit fe, input bit pe);
        return {1'b1, ovr, fe, pe, 2'b00, 2'(line), ch};
    endfunction

    task automatic deliver(input logic [3:0] m, input logic [31:0] ch,
                           input logic [3:0] fe, input logic [3:0] pe);
        @(negedge clk);
        ln_stb = m; ln_char = ch; ln_ferr = fe; ln_perr = pe;
        @(negedge clk);
        ln_stb = '0; ln_ferr = '0; ln_perr = '0;
    endtask

    task automatic read_word(output logic [15:0] w);
        @(negedge clk);
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic lp_write(input int line, input bit en, input logic [3:0] baud,
                            input bit odd, input bit pen, input bit stop,
                            input logic [1:0] size);
        @(negedge clk);
        lp_wr = 1'b1;
        lp_data = {en, baud, odd, pen, stop, size, 3'(line)};
        @(negedge clk);
        lp_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 rx_done", 16'(rx_done), 16'h0);
        check("R11 rd_data", rd_data, 16'h0000);
        check("R11 rxen", 16'(line_rxen), 16'h0);
        check("R11 size", 16'(line_size), 16'h00FF);
        check("R11 baud", line_baud, 16'h0000);
        check("R6 irq idle", 16'(rx_irq), 16'h0);

        // R8 strobe on a disabled line
        deliver(4'b0001, 32'h0000_0012, 4'h0, 4'h0);
        check("R8 disabled line", 16'(rx_done), 16'h0);

        // R7 parameter writes
        lp_write(0, 1, 4'h0, 0, 0, 0, 2'b11);
        lp_write(1, 1, 4'h0, 0, 0, 0, 2'b11);
        lp_write(2, 1, 4'h7, 1, 1, 1, 2'b01);
        lp_write(3, 1, 4'h0, 0, 0, 0, 2'b11);
        lp_write(5, 0, 4'hF, 1, 1, 1, 2'b00);   // out-of-range select
        check("R7 rxen", 16'(line_rxen), 16'h000F);
        check("R7 baud", line_baud, 16'h0700);
        check("R7 size", 16'(line_size), 16'h00DF);
        check("R7 stop/par/odd", {4'h0, line_stop, line_par_en, line_par_odd}, 16'h0444);

        // vector table: R1 R3 R5 R6 R4
        for (int k = 0; k < NV; k++) begin
            rie = k[0];
            deliver(4'(1) << VEC[k][27:26], 32'(VEC[k][25:18]) << (8*VEC[k][27:26]),
                    4'(VEC[k][17]) << VEC[k][27:26], 4'(VEC[k][16]) << VEC[k][27:26]);
            check("R3 rx_done", 16'(rx_done), 16'h1);
            check("R6 irq", 16'(rx_irq), 16'(k[0]));
            read_word(w);
            check("R1 R5 word", w, VEC[k][15:0]);
            check("R4 empty read", rd_data, 16'h0000);
        end
        rie = 1'b0;

        // R10 same-cycle arrivals, ascending order
        deliver(4'b1011, 32'h3300_2211, 4'h0, 4'h0);
        read_word(w); check("R10 first", w, word(0, 8'h11, 0, 0, 0));
        read_word(w); check("R10 second", w, word(1, 8'h22, 0, 0, 0));
        read_word(w); check("R10 third", w, word(3, 8'h33, 0, 0, 0));
        check("R4 drained", rd_data, 16'h0000);

        // R9 fill, drop, overrun marker
        for (int c = 0; c < 4; c++)
            deliver(4'b1111, {4'(c), 4'd3, 4'(c), 4'd2, 4'(c), 4'd1, 4'(c), 4'd0},
                    4'h0, 4'h0);
        deliver(4'b0100, 32'h0099_0000, 4'h0, 4'h0);   // dropped
        read_word(w); check("R9 head", w, word(0, 8'h00, 0, 0, 0));
        deliver(4'b0010, 32'h0000_5500, 4'h0, 4'h0);
        for (int e = 1; e < 16; e++) begin
            read_word(w);
            check("R2 R9 order", w, word(e % 4, {4'(e / 4), 4'(e % 4)}, 0, 0, 0));
        end
        read_word(w); check("R9 overrun mark", w, word(1, 8'h55, 1, 0, 0));
        check("R9 drop gone", rd_data, 16'h0000);
        deliver(4'b0001, 32'h0000_0066, 4'h0, 4'h0);
        read_word(w); check("R9 mark once", w, word(0, 8'h66, 0, 0, 0));

        // R8 one disabled line among enabled ones
        lp_write(2, 0, 4'h0, 0, 0, 0, 2'b11);
        check("R8 rxen", 16'(line_rxen), 16'h000B);
        deliver(4'b1111, 32'hA3A2_A1A0, 4'h0, 4'h0);
        read_word(w); check("R8 mix a", w, word(0, 8'hA0, 0, 0, 0));
        read_word(w); check("R8 mix b", w, word(1, 8'hA1, 0, 0, 0));
        read_word(w); check("R8 mix c", w, word(3, 8'hA3, 0, 0, 0));
        check("R8 mix empty", rd_data, 16'h0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule